// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block is the digital sweep engine of a spread-spectrum clock generator. On every reference clock edge it presents a signed frequency-offset code. The code is meant for a current-output DAC that pulls a PLL oscillator slightly off its nominal frequency. Over time the code traces a periodic triangle, which spreads the clock energy across a band and lowers the peak of the radiated emission.

Two select inputs choose one of four profiles. Two are symmetric around the nominal point and two only pull the frequency below it. An enable input switches modulation off; the code then rests at zero offset. Both inputs pass through two-flop synchronizers. Whenever the synchronized setting changes, the triangle restarts from zero and a settle counter is reloaded. A `settled` output stays low until that counter runs out, so downstream logic knows when the PLL may be trusted again.

Top module: `ssm_profile_gen`

## Requirements
- R1: The code is in units of 0.1% of nominal frequency. The select value {selIn[1],selIn[0]} picks the sweep limits: 00 gives +15/-15, 01 gives +5/-5, 10 gives 0/-10 and 11 gives 0/-30. Each full sweep reaches both of its limits.
- R2: In the two symmetric profiles (select 00, 01) the code starts at 0 after a restart and first rises. It moves one LSB per step up to the upper limit, then down to the lower limit, and back, with no dwell at the turning points.
- R3: In the two below-nominal profiles (select 10, 11) the code starts at 0 after a restart and first falls to the lower limit, then climbs back to 0. It is never positive.
- R4: While the synchronized enable is low, the code is 0 on every cycle.
- R5: During reset the code is 0 and `settled` is low. Enable resets to the "on" state and select resets to 00, so with those inputs held, `settled` rises exactly SETTLE_CYCLES cycles after reset is released, with no extra restart.
- R6: After a change on selIn or enableIn, `settled` is low from the third clock edge on. It rises exactly SETTLE_CYCLES edges after that third edge.
- R7: One step lasts SWEEP_CYCLES/60 cycles in the ±1.5% and 3.0% profiles and SWEEP_CYCLES/20 cycles in the other two. One full triangle therefore spans SWEEP_CYCLES reference cycles.
- R8: A setting change restarts the sweep: the code is 0 after the third edge following the input change, and the first step comes one full step interval later.
- R9: Between any two consecutive cycles the code changes by at most one LSB, except for the jump to 0 on a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| selIn | input | 2 | Profile select, asynchronous to clk |
| enableIn | input | 1 | Modulation enable, asynchronous to clk |
| offsetCode | output | 6 | Signed offset code in 0.1% units |
| settled | output | 1 | High once the settle wait after the last setting change has elapsed |

## Verification
The bench walks every profile, including a change that only toggles enable and a select change made while enable is low. For each one it predicts the code cycle by cycle from the triangle formula and checks every sample for two full periods. A design that starts a down-spread sweep upward, dwells at a turning point or uses the wrong step interval drifts off the predicted sequence within a few steps. One that misses a restart shows a non-zero code on the third cycle after the change. The settle window is checked to the exact cycle on both edges, so an off-by-one in the counter or the synchronizer depth, or a missed reload, shows up as a mismatch on `settled`.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int CODE_W = 6;
  localparam int FINE_SPAN = 30;   // peak-to-peak steps of the wide profiles
  localparam int COARSE_SPAN = 10; // peak-to-peak steps of the narrow profiles

  typedef logic signed [CODE_W-1:0] code_t;

  typedef struct packed {
    logic restart;
    logic stepTick;
    logic startDown;
  } ctlStrobe_t;

  function automatic code_t profileHi(input logic [1:0] sel);
    case (sel)
      2'b00: return code_t'(15);
      2'b01: return code_t'(5);
      default: return code_t'(0);
    endcase
  endfunction

  function automatic code_t profileLo(input logic [1:0] sel);
    case (sel)
      2'b00: return code_t'(-15);
      2'b01: return code_t'(-5);
      2'b10: return code_t'(-10);
      default: return code_t'(-30);
    endcase
  endfunction

  function automatic logic isWideSpan(input logic [1:0] sel);
    return (sel == 2'b00) || (sel == 2'b11);
  endfunction
endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int SWEEP_CYCLES = 2000,
  parameter int SETTLE_CYCLES = 625000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] selIn,
  input  logic       enableIn,
  output ctlStrobe_t strobe,
  output logic [1:0] cfgSel,
  output logic       cfgEn,
  output logic       settled
);
  localparam int STEP_FINE = SWEEP_CYCLES / (2 * FINE_SPAN);
  localparam int STEP_COARSE = SWEEP_CYCLES / (2 * COARSE_SPAN);
  localparam int STEP_W = $clog2(STEP_COARSE + 1);
  localparam int SETTLE_W = $clog2(SETTLE_CYCLES + 1);

  logic [1:0] selMeta, selSync;
  logic enMeta, enSync;
  logic changeSeen;
  logic [STEP_W-1:0] stepCnt, stepLast;
  logic [SETTLE_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selMeta <= 2'b00;
      selSync <= 2'b00;
      enMeta <= 1'b1;
      enSync <= 1'b1;
    end else begin
      selMeta <= selIn;
      selSync <= selMeta;
      enMeta <= enableIn;
      enSync <= enMeta;
    end
  end

  assign changeSeen = (selSync != cfgSel) || (enSync != cfgEn);
  assign stepLast = isWideSpan(cfgSel) ? STEP_W'(STEP_FINE - 1) : STEP_W'(STEP_COARSE - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSel <= 2'b00;
      cfgEn <= 1'b1;
      stepCnt <= '0;
      settleCnt <= SETTLE_W'(SETTLE_CYCLES);
    end else if (changeSeen) begin
      cfgSel <= selSync;
      cfgEn <= enSync;
      stepCnt <= '0;
      settleCnt <= SETTLE_W'(SETTLE_CYCLES);
    end else begin
      stepCnt <= (stepCnt == stepLast) ? '0 : stepCnt + 1'b1;
      if (settleCnt != '0) settleCnt <= settleCnt - 1'b1;
    end
  end

  always_comb begin
    strobe.restart = changeSeen;
    strobe.stepTick = !changeSeen && (stepCnt == stepLast);
    strobe.startDown = selSync[1];
  end

  assign settled = (settleCnt == '0);
endmodule

// File: rtl/ssm_datapath.sv
module ssm_datapath
  import ssm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  logic [1:0] cfgSel,
  input  logic       cfgEn,
  output code_t      offsetCode
);
  logic goingUp;
  code_t nextCode, hiLim, loLim;

  assign hiLim = profileHi(cfgSel);
  assign loLim = profileLo(cfgSel);
  assign nextCode = goingUp ? offsetCode + code_t'(1) : offsetCode - code_t'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetCode <= '0;
      goingUp <= 1'b1;
    end else if (strobe.restart) begin
      offsetCode <= '0;
      goingUp <= !strobe.startDown;
    end else if (strobe.stepTick && cfgEn) begin
      offsetCode <= nextCode;
      if (nextCode == hiLim) goingUp <= 1'b0;
      else if (nextCode == loLim) goingUp <= 1'b1;
    end
  end
endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
  import ssm_pkg::*;
#(
  parameter int SWEEP_CYCLES = 2000,
  parameter int SETTLE_CYCLES = 625000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [1:0]               selIn,
  input  logic                     enableIn,
  output logic signed [CODE_W-1:0] offsetCode,
  output logic                     settled
);
  ctlStrobe_t strobe;
  logic [1:0] cfgSel;
  logic cfgEn;

  ssm_ctrl #(.SWEEP_CYCLES(SWEEP_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .selIn(selIn), .enableIn(enableIn),
    .strobe(strobe), .cfgSel(cfgSel), .cfgEn(cfgEn), .settled(settled)
  );

  ssm_datapath data_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgSel(cfgSel), .cfgEn(cfgEn),
    .offsetCode(offsetCode)
  );
endmodule

// File: rtl/ssm_profile_chk.sv
module ssm_profile_chk
  import ssm_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] selIn,
  input logic       enableIn,
  input code_t      offsetCode,
  input logic       settled,
  input logic [1:0] cfgSel,
  input logic       cfgEn
);
  AST_WITHIN_LIMITS: assert property (@(posedge clk) disable iff (!rstN)
    offsetCode <= profileHi(cfgSel) && offsetCode >= profileLo(cfgSel)); // R1

  AST_DOWN_NOT_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    cfgSel[1] |-> offsetCode <= 0); // R3

  AST_OFF_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEn |-> offsetCode == 0); // R4

  AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (selIn != $past(selIn) || enableIn != $past(enableIn)) |-> ##3 !settled); // R6

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (offsetCode != $past(offsetCode)) |->
      (offsetCode == 0 || offsetCode - $past(offsetCode) == 1 ||
       $past(offsetCode) - offsetCode == 1)); // R9
endmodule

bind ssm_profile_gen ssm_profile_chk chk_i (
  .clk(clk), .rstN(rstN), .selIn(selIn), .enableIn(enableIn),
  .offsetCode(offsetCode), .settled(settled), .cfgSel(cfgSel), .cfgEn(cfgEn)
);

// File: tb/ssm_profile_gen_tb.sv
module ssm_profile_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SWEEP = 120;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] selIn = 2'b00;
  logic enableIn = 1'b1;
  logic signed [5:0] offsetCode;
  logic settled;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssm_profile_gen #(.SWEEP_CYCLES(SWEEP), .SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rstN(rstN), .selIn(selIn), .enableIn(enableIn),
    .offsetCode(offsetCode), .settled(settled)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  function automatic int expCode(input logic [1:0] sel, input int k);
    int a, p;
    if (sel[1] == 1'b0) begin
      a = (sel == 2'b00) ? 15 : 5;
      p = k % (4 * a);
      if (p <= a) return p;
      if (p <= 3 * a) return 2 * a - p;
      return p - 4 * a;
    end
    a = (sel == 2'b10) ? 10 : 30;
    p = k % (2 * a);
    return (p <= a) ? -p : p - 2 * a;
  endfunction

  task automatic runConfig(input logic [1:0] sel, input logic en);
    int step, maxSeen, minSeen, prev, total;
    step = (sel == 2'b00 || sel == 2'b11) ? SWEEP / 60 : SWEEP / 20;
    total = 3 + SETTLE + 2 * SWEEP;
    maxSeen = -100;
    minSeen = 100;
    prev = offsetCode;
    selIn = sel;
    enableIn = en;
    for (int n = 1; n <= total; n++) begin
      @(negedge clk);
      if (n >= 3) begin
        check("R6 settled", settled, (n >= 3 + SETTLE) ? 1 : 0);
        if (n == 3) check("R8 restart at zero", offsetCode, 0);
        else if (!en) check("R4 code when off", offsetCode, 0);
        else if (sel[1]) check("R3 R7 down sweep", offsetCode, expCode(sel, (n - 3) / step));
        else check("R2 R7 center sweep", offsetCode, expCode(sel, (n - 3) / step));
        if (n > 3) check("R9 single step", (offsetCode - prev) * (offsetCode - prev) <= 1, 1);
        if (offsetCode > maxSeen) maxSeen = offsetCode;
        if (offsetCode < minSeen) minSeen = offsetCode;
      end
      prev = offsetCode;
    end
    if (en) begin
      check("R1 upper limit", maxSeen, sel == 2'b00 ? 15 : sel == 2'b01 ? 5 : 0);
      check("R1 lower limit", minSeen, sel == 2'b00 ? -15 : sel == 2'b01 ? -5 : sel == 2'b10 ? -10 : -30);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R5 reset code", offsetCode, 0);
    check("R5 reset settled", settled, 0);
    rstN = 1'b1;
    for (int n = 1; n <= SETTLE; n++) begin
      @(negedge clk);
      check("R5 default settle", settled, (n == SETTLE) ? 1 : 0);
    end
    runConfig(2'b01, 1'b1);
    runConfig(2'b00, 1'b1);
    runConfig(2'b10, 1'b1);
    runConfig(2'b11, 1'b1);
    runConfig(2'b11, 1'b0);
    runConfig(2'b10, 1'b0);
    runConfig(2'b10, 1'b1);
    runConfig(2'b00, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule